// File: doc/BRIEF.md
# Hash Engine Scatter-Gather Fetcher

This block is the command and memory-access front end of a memory-to-memory hash accelerator. Software sets a source pointer, a digest pointer, a byte count and an optional key-buffer pointer, then writes a command word to start a job. The command word picks the digest algorithm and the source mode. In direct mode the block reads the byte count from one contiguous region. In scatter-gather mode the source pointer instead addresses a list of 8-byte descriptors in memory. The block walks this list and streams every fragment in turn.

The bytes go to a hash core over a valid/ready byte port. The core is outside this block; the bench models it with a stub. Once the stream is done, the block reads the digest bytes from the core by index and writes them to the digest pointer. It then drops its busy flag and raises a completion flag. Software clears that flag by writing a one to it.

Memory is byte-wide. A read issued with `mem_rd` returns its byte on `mem_rdata` in the next cycle. A write issued with `mem_wr` is always accepted in its own cycle.

Top module: `hash_sg_fetch`

## Requirements
- R1: After reset, every register reads zero: status at offset 0x1C, source 0x20, digest 0x24, key 0x28, length 0x2C and command 0x30. The `irq` output is low.
- R2: When idle, the source, digest, key, length and command registers each read back the full 32-bit value last written to them.
- R3: A command write while idle starts a job. `hc_start` pulses high in the write cycle. Status bit 0 (busy) reads 1 from the next cycle until the digest write-back ends. Status bits other than 0 and 9 always read 0.
- R4: In direct mode (command bit 18 clear), the block streams exactly the programmed length of bytes to the core. It reads them from ascending addresses starting at the source pointer. While `hc_valid` is high and `hc_ready` is low, `hc_valid` and `hc_data` hold.
- R5: In scatter-gather mode (command bit 18 set), descriptors are read from the source pointer onward at a stride of 8 bytes. Each descriptor is two little-endian 32-bit words: the length word at +0 and the fragment address at +4. Length bits 30:0 give the fragment size. Bit 31 marks the last descriptor, and no descriptor is read after it. The length register has no effect in this mode.
- R6: A zero-length fragment, or a direct job of length zero, causes no data read. Only the 8 descriptor byte reads occur for such a fragment.
- R7: The digest size comes from command bits {10,6,5,4}: 0000 gives 16 bytes, 0010 gives 20, 0100 gives 28, 0101 gives 32, 0110 gives 64, 1110 gives 48, and any other code gives 32. Digest byte i is the core's `dg_byte` while `dg_idx` = i. It is written to the digest pointer plus i, in ascending i.
- R8: When write-back ends, status bit 9 and `irq` go high in the same cycle that busy drops. Writing 1 to status bit 9 clears it. Writing 0 there has no effect.
- R9: A command write while busy is ignored. The command register keeps its value, and no new `hc_start` or job follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_rd | output | 1 | Memory byte read request |
| mem_wr | output | 1 | Memory byte write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after mem_rd |
| hc_start | output | 1 | One-cycle pulse at the start of a job |
| hc_valid | output | 1 | Byte to core is valid |
| hc_data | output | 8 | Byte to core |
| hc_ready | input | 1 | Core accepts the byte |
| dg_idx | output | 6 | Digest byte index requested from core |
| dg_byte | input | 8 | Digest byte for dg_idx |
| irq | output | 1 | Completion flag (status bit 9) |

## Verification
The stream is tested with a three-byte direct job and a zero-length direct job. It is also tested with a four-entry descriptor list that contains a zero-length fragment. The zero-length cases tell apart an engine that skips empty fragments from one that issues stray reads; the bench counts every memory read to see this. Byte order and backpressure come from a core-ready pattern that toggles pseudo-randomly against the byte-by-byte scoreboard. Digest jobs with five different algorithm codes tell apart the write-back lengths. A guard byte just past each digest catches any overrun.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 32;

    localparam logic [7:0] OFF_STAT = 8'h1C;
    localparam logic [7:0] OFF_SRC  = 8'h20;
    localparam logic [7:0] OFF_DST  = 8'h24;
    localparam logic [7:0] OFF_KEY  = 8'h28;
    localparam logic [7:0] OFF_LEN  = 8'h2C;
    localparam logic [7:0] OFF_CMD  = 8'h30;

    localparam int BIT_SG   = 18;
    localparam int BIT_BUSY = 0;
    localparam int BIT_DONE = 9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DREQ,
        S_DCAP,
        S_NEXT,
        S_RREQ,
        S_RCAP,
        S_SEND,
        S_WB
    } eng_state_e;

    function automatic logic [6:0] digest_bytes(input logic [REG_W-1:0] cmd);
        case ({cmd[10], cmd[6], cmd[5], cmd[4]})
            4'b0000: digest_bytes = 7'd16;
            4'b0010: digest_bytes = 7'd20;
            4'b0100: digest_bytes = 7'd28;
            4'b0101: digest_bytes = 7'd32;
            4'b0110: digest_bytes = 7'd64;
            4'b1110: digest_bytes = 7'd48;
            default: digest_bytes = 7'd32;
        endcase
    endfunction

endpackage

// File: rtl/hsf_regs.sv
module hsf_regs
    import hsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             busy,
    input  logic             done,
    output logic             start,
    output logic [REG_W-1:0] start_cmd,
    output logic [REG_W-1:0] src,
    output logic [REG_W-1:0] dst,
    output logic [REG_W-1:0] len,
    output logic             irq
);

    typedef struct packed {
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] key;
        logic [REG_W-1:0] len;
        logic [REG_W-1:0] cmd;
        logic             irq;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        start     = 1'b0;
        start_cmd = wdata;
        if (we) begin
            case (addr)
                OFF_SRC:  r_d.src = wdata;
                OFF_DST:  r_d.dst = wdata;
                OFF_KEY:  r_d.key = wdata;
                OFF_LEN:  r_d.len = wdata;
                OFF_CMD: begin
                    if (!busy) begin
                        r_d.cmd = wdata;
                        start   = 1'b1;
                    end
                end
                OFF_STAT: if (wdata[BIT_DONE]) r_d.irq = 1'b0;
                default: ;
            endcase
        end
        if (done) r_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_STAT: begin
                rdata[BIT_BUSY] = busy;
                rdata[BIT_DONE] = r_q.irq;
            end
            OFF_SRC: rdata = r_q.src;
            OFF_DST: rdata = r_q.dst;
            OFF_KEY: rdata = r_q.key;
            OFF_LEN: rdata = r_q.len;
            OFF_CMD: rdata = r_q.cmd;
            default: rdata = '0;
        endcase
    end

    assign src = r_q.src;
    assign dst = r_q.dst;
    assign len = r_q.len;
    assign irq = r_q.irq;

endmodule

// File: rtl/hsf_engine.sv
module hsf_engine
    import hsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  cmd,
    input  logic [REG_W-1:0]  src,
    input  logic [REG_W-1:0]  dst,
    input  logic [REG_W-1:0]  len,
    output logic              busy,
    output logic              done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              hc_valid,
    output logic [7:0]        hc_data,
    input  logic              hc_ready,
    output logic [5:0]        dg_idx,
    input  logic [7:0]        dg_byte
);

    localparam int DESC_BYTES = 8;
    localparam int BCNT_W     = $clog2(DESC_BYTES);

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] cur;
        logic [REG_W-1:0]  remain;
        logic              last;
        logic [BCNT_W-1:0] bcnt;
        logic [63:0]       dbuf;
        logic [7:0]        byte_q;
        logic [5:0]        idx;
        logic [6:0]        dlen;
        logic [ADDR_W-1:0] dst;
    } eng_t;

    eng_t e_q, e_d;
    logic [63:0] nbuf;

    always_comb begin
        e_d       = e_q;
        done      = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        hc_valid  = 1'b0;
        nbuf      = e_q.dbuf;
        nbuf[{e_q.bcnt, 3'b000} +: 8] = mem_rdata;

        case (e_q.st)
            S_IDLE: begin
                if (start) begin
                    e_d.dlen = digest_bytes(cmd);
                    e_d.dst  = dst;
                    e_d.idx  = '0;
                    e_d.bcnt = '0;
                    if (cmd[BIT_SG]) begin
                        e_d.ptr = src;
                        e_d.st  = S_DREQ;
                    end else begin
                        e_d.cur    = src;
                        e_d.remain = len;
                        e_d.last   = 1'b1;
                        e_d.st     = S_NEXT;
                    end
                end
            end
            S_DREQ: begin
                mem_rd   = 1'b1;
                mem_addr = e_q.ptr + ADDR_W'(e_q.bcnt);
                e_d.st   = S_DCAP;
            end
            S_DCAP: begin
                e_d.dbuf = nbuf;
                if (e_q.bcnt == BCNT_W'(DESC_BYTES - 1)) begin
                    e_d.remain = {1'b0, nbuf[30:0]};
                    e_d.last   = nbuf[31];
                    e_d.cur    = nbuf[63:32];
                    e_d.ptr    = e_q.ptr + ADDR_W'(DESC_BYTES);
                    e_d.bcnt   = '0;
                    e_d.st     = S_NEXT;
                end else begin
                    e_d.bcnt = e_q.bcnt + 1'b1;
                    e_d.st   = S_DREQ;
                end
            end
            S_NEXT: begin
                if (e_q.remain != '0) e_d.st = S_RREQ;
                else if (e_q.last)    e_d.st = S_WB;
                else                  e_d.st = S_DREQ;
            end
            S_RREQ: begin
                mem_rd   = 1'b1;
                mem_addr = e_q.cur;
                e_d.st   = S_RCAP;
            end
            S_RCAP: begin
                e_d.byte_q = mem_rdata;
                e_d.st     = S_SEND;
            end
            S_SEND: begin
                hc_valid = 1'b1;
                if (hc_ready) begin
                    e_d.cur    = e_q.cur + 1'b1;
                    e_d.remain = e_q.remain - 1'b1;
                    e_d.st     = S_NEXT;
                end
            end
            S_WB: begin
                mem_wr    = 1'b1;
                mem_addr  = e_q.dst + ADDR_W'(e_q.idx);
                mem_wdata = dg_byte;
                if ({1'b0, e_q.idx} == e_q.dlen - 7'd1) begin
                    done   = 1'b1;
                    e_d.st = S_IDLE;
                end else begin
                    e_d.idx = e_q.idx + 1'b1;
                end
            end
            default: e_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= S_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy    = (e_q.st != S_IDLE);
    assign hc_data = e_q.byte_q;
    assign dg_idx  = e_q.idx;

endmodule

// File: rtl/hash_sg_fetch.sv
module hash_sg_fetch
    import hsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              hc_start,
    output logic              hc_valid,
    output logic [7:0]        hc_data,
    input  logic              hc_ready,
    output logic [5:0]        dg_idx,
    input  logic [7:0]        dg_byte,
    output logic              irq
);

    logic             busy_w;
    logic             done_w;
    logic             start_w;
    logic [REG_W-1:0] cmd_w, src_w, dst_w, len_w;

    hsf_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy      (busy_w),
        .done      (done_w),
        .start     (start_w),
        .start_cmd (cmd_w),
        .src       (src_w),
        .dst       (dst_w),
        .len       (len_w),
        .irq       (irq)
    );

    hsf_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .cmd       (cmd_w),
        .src       (src_w),
        .dst       (dst_w),
        .len       (len_w),
        .busy      (busy_w),
        .done      (done_w),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .hc_valid  (hc_valid),
        .hc_data   (hc_data),
        .hc_ready  (hc_ready),
        .dg_idx    (dg_idx),
        .dg_byte   (dg_byte)
    );

    assign hc_start = start_w;

endmodule

// File: rtl/hash_sg_fetch_chk.sv
module hash_sg_fetch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic       busy,
    input logic       irq,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       hc_start,
    input logic       hc_valid,
    input logic [7:0] hc_data,
    input logic       hc_ready
);

    a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        hc_start |=> busy);

    a_r3_cmd_while_idle_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h30 && !busy) |-> hc_start);

    a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_valid && !hc_ready) |=> (hc_valid && $stable(hc_data)));

    a_r7_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r7_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> busy);

    a_r8_irq_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !hc_start);

endmodule

bind hash_sg_fetch hash_sg_fetch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .busy     (busy_w),
    .irq      (irq),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .hc_start (hc_start),
    .hc_valid (hc_valid),
    .hc_data  (hc_data),
    .hc_ready (hc_ready)
);

// File: tb/hash_sg_fetch_test.sv
module hash_sg_fetch_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        hc_start, hc_valid;
    logic [7:0]  hc_data;
    logic        hc_ready = 1'b0;
    logic [5:0]  dg_idx;
    logic [7:0]  dg_byte;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int rd_count = 0;
    int start_count = 0;
    int cycles = 0;
    logic [7:0] mem [0:4095];
    logic [7:0] exp_q [$];
    logic [7:0] stub_sum = '0;
    logic [7:0] exp_sum = '0;
    logic [15:0] lfsr = 16'hACE1;

    hash_sg_fetch uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .hc_start(hc_start), .hc_valid(hc_valid),
        .hc_data(hc_data), .hc_ready(hc_ready), .dg_idx(dg_idx),
        .dg_byte(dg_byte), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model and stub hash core
    assign dg_byte = stub_sum + {2'b00, dg_idx};

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[11:0]];
            rd_count  <= rd_count + 1;
        end
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (hc_start) begin
            stub_sum    <= '0;
            start_count <= start_count + 1;
        end else if (hc_valid && hc_ready) begin
            stub_sum <= stub_sum + hc_data;
        end
    end

    // pseudo-random ready pattern
    always @(negedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        hc_ready <= lfsr[0] | lfsr[3];
    end

    // scoreboard monitor
    always @(posedge clk) begin
        if (rst_n && hc_valid && hc_ready) begin
            checks = checks + 1;
            if (exp_q.size() == 0) begin
                fails = fails + 1;
                $display("FAIL R4/R5: unexpected byte %02h, expected none", hc_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (hc_data !== e) begin
                    fails = fails + 1;
                    $display("FAIL R4/R5: stream byte %02h expected %02h", hc_data, e);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // driver: place data bytes and push expected stream
    task automatic put_bytes(input int addr, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'(seed + 7 * i);
            mem[12'(addr + i)] = b;
            exp_q.push_back(b);
            exp_sum = exp_sum + b;
        end
    endtask

    task automatic put_desc(input int addr, input logic [30:0] n, input logic [31:0] fa, input logic last);
        logic [31:0] w0;
        w0 = {last, n};
        for (int i = 0; i < 4; i++) begin
            mem[12'(addr + i)]     = w0[8*i +: 8];
            mem[12'(addr + 4 + i)] = fa[8*i +: 8];
        end
    endtask

    task automatic wait_irq();
        int t;
        t = 0;
        while (!irq && t < 5000) begin
            @(posedge clk);
            t++;
        end
        #1;
    endtask

    task automatic check_digest(input string req, input int dst, input int n);
        for (int i = 0; i < n; i++)
            check(req, {24'h0, mem[12'(dst + i)]}, {24'h0, exp_sum + 8'(i)});
        check({req, " guard"}, {24'h0, mem[12'(dst + n)]}, 32'h000000EE);
    endtask

    task automatic guard(input int dst);
        for (int i = 0; i < 72; i++) mem[12'(dst + i)] = 8'hEE;
    endtask

    task automatic clear_done();
        logic [31:0] v;
        wr(8'h1C, 32'h0);
        rd(8'h1C, v);
        check("R8 write 0 keeps flag", v, 32'h00000200);
        wr(8'h1C, 32'h00000200);
        rd(8'h1C, v);
        check("R8 w1c clears", v, 32'h0);
        check("R8 irq low", {31'h0, irq}, 32'h0);
    endtask

    task automatic direct_job(input int src, input int dst, input int n, input logic [31:0] cmd, input int dlen, input string tag);
        logic [31:0] v;
        exp_sum = '0;
        guard(dst);
        put_bytes(src, n, src + n);
        wr(8'h20, src); wr(8'h24, dst); wr(8'h2C, n);
        rd_count = 0;
        wr(8'h30, cmd);
        rd(8'h1C, v);
        check({tag, " R3 busy"}, v, 32'h1);
        wait_irq();
        rd(8'h1C, v);
        check({tag, " R8 done status"}, v, 32'h00000200);
        check({tag, " R4 read count"}, rd_count, n);
        check({tag, " R4 stream drained"}, exp_q.size(), 0);
        check_digest({tag, " R7 digest"}, dst, dlen);
        clear_done();
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < WATCHDOG; wd++) @(posedge clk);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h1C, v); check("R1 status", v, 0);
        rd(8'h20, v); check("R1 src", v, 0);
        rd(8'h24, v); check("R1 dst", v, 0);
        rd(8'h28, v); check("R1 key", v, 0);
        rd(8'h2C, v); check("R1 len", v, 0);
        rd(8'h30, v); check("R1 cmd", v, 0);
        check("R1 irq", {31'h0, irq}, 0);

        // R2 readback
        wr(8'h20, 32'hFFFFFFFF); rd(8'h20, v); check("R2 src", v, 32'hFFFFFFFF);
        wr(8'h24, 32'h13579BDF); rd(8'h24, v); check("R2 dst", v, 32'h13579BDF);
        wr(8'h28, 32'hA5A5_0F0F); rd(8'h28, v); check("R2 key", v, 32'hA5A50F0F);
        wr(8'h2C, 32'h8000_0001); rd(8'h2C, v); check("R2 len", v, 32'h80000001);

        // R4 R7: direct MD5, 3 bytes
        direct_job(32'h100, 32'h800, 3, 32'h0000_0008, 16, "md5");
        // R7: SHA-512 zero length, R6 no reads
        direct_job(32'h140, 32'h880, 0, 32'h0000_0068, 64, "sha512 len0");
        // R7: SHA-384 and SHA-1
        direct_job(32'h180, 32'h900, 5, 32'h0000_0468, 48, "sha384");
        direct_job(32'h1C0, 32'h980, 9, 32'h0000_0028, 20, "sha1");

        // R5 R6 R9: scatter-gather SHA-256 with a zero-length entry
        exp_sum = '0;
        guard(32'hA00);
        put_desc(32'h200, 31'd6, 32'h300, 1'b0);
        put_desc(32'h208, 31'd0, 32'h380, 1'b0);
        put_desc(32'h210, 31'd3, 32'h400, 1'b0);
        put_desc(32'h218, 31'd3, 32'h480, 1'b1);
        put_desc(32'h220, 31'd4, 32'h500, 1'b1);
        put_bytes(32'h300, 6, 32'h61);
        put_bytes(32'h400, 3, 32'h67);
        put_bytes(32'h480, 3, 32'h6A);
        wr(8'h20, 32'h200); wr(8'h24, 32'hA00); wr(8'h2C, 32'd999);
        rd_count = 0;
        s0 = start_count;
        wr(8'h30, 32'h0004_0058);
        wr(8'h30, 32'h0000_0000);
        rd(8'h30, v);
        check("R9 cmd kept while busy", v, 32'h0004_0058);
        wait_irq();
        check("R9 single start", start_count - s0, 1);
        check("R5 R6 read count", rd_count, 4 * 8 + 12);
        check("R5 stream drained", exp_q.size(), 0);
        check_digest("R5 R7 sha256 digest", 32'hA00, 32);
        rd(8'h1C, v);
        check("R8 sg done", v, 32'h00000200);
        clear_done();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule